// File: doc/BRIEF.md
# Hotplug General-Purpose Event Register Block

This block holds the event registers a platform uses to announce processor and slot hotplug to system software. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time. Beside them sit a byte-addressed processor presence bitmap, two 32-bit slot masks (arrivals and departures), and an eject register. Software writes the eject register to name a slot to be removed, and the block reports that slot on a strobe.

Hotplug events come in on two strobed inputs, one for processors and one for slots. Each event updates the matching bitmap and latches a status bit. When the matching enable bit is set, the event also produces a one-cycle interrupt pulse. All registers share one 16-bit address bus. Four address windows are decoded from parameterised base addresses, and any address outside them reads as zero and ignores writes.

Top module: `hp_gpe_hotplug`

## Requirements
- R1: After reset the status, enable, arrival and departure registers are zero, `sci_pulse` and `eject_valid` are low, and presence bits 0 to INIT_CPUS-1 are set while all others are clear.
- R2: A byte write to the status window clears only the bits written as one, and only in the addressed byte. Offset 0 is bits 7:0 and offset 1 is bits 15:8.
- R3: A byte write to enable offset 2 replaces enable bits 7:0, and a write to offset 3 replaces bits 15:8. The other byte is unchanged.
- R4: The presence window reads byte k as processors 8k to 8k+7, with bit j of that byte being processor 8k+j. Bus writes to the presence window change nothing.
- R5: A processor event sets (add) or clears (remove) presence bit `cpu_evt_id` and sets status bit 2.
- R6: A slot event first clears both slot masks. It then sets bit `slot_evt_id` in the arrival mask (add) or in the departure mask (remove), and sets status bit 1.
- R7: `sci_pulse` is high for the one cycle after a processor event if enable bit 2 was set, or after a slot event if enable bit 1 was set. It is low otherwise.
- R8: The arrival mask is read and written as a 32-bit word at slot-window offset 0, and the departure mask at offset 4.
- R9: A write of a nonzero word to the eject window raises `eject_valid` for one cycle in the next cycle. `eject_slot` then holds the index of the lowest set bit of the word. A zero write raises no strobe, and the eject window always reads zero.
- R10: Addresses outside the four windows read zero, and writes to them change no register.
- R11: In a cycle where an event and a bus write meet, the event wins: its status bit stays set and its slot-mask update takes precedence over the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data (byte windows use bits 7:0) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_evt_valid | input | 1 | Processor hotplug event strobe |
| cpu_evt_add | input | 1 | 1 = processor added, 0 = removed |
| cpu_evt_id | input | CPU_ID_W (8) | Processor index |
| slot_evt_valid | input | 1 | Slot hotplug event strobe |
| slot_evt_add | input | 1 | 1 = slot added, 0 = removed |
| slot_evt_id | input | SLOT_ID_W (5) | Slot index |
| sci_pulse | output | 1 | One-cycle event interrupt pulse |
| eject_valid | output | 1 | One-cycle eject request strobe |
| eject_slot | output | SLOT_ID_W (5) | Slot named by the eject request |

## Verification
The bench sweeps events across the processor index space and every slot, then reads back the presence bytes and the masks. A presence map with the byte and bit swapped, or with removes ignored, would read back wrong. A wrongly decoded byte lane is caught because the status clear and the enable writes land in each byte in turn: a design that cleared or replaced the whole word, or the wrong half, would disturb the other byte. The bench also drives an event in the same cycle as a colliding bus write, which exposes a design that let the write win and lost a status bit or a mask update. It writes eject words with every possible lowest set bit and also the zero word, which catches a priority encoder picking the highest bit and a strobe raised on zero.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the hotplug event register block.
package hp_pkg;
    // Status/enable bit positions that the two event sources own.
    localparam int STS_SLOT_BIT = 1;
    localparam int STS_CPU_BIT  = 2;
    localparam int EVT_REG_W    = 16;

    // Address window hit by the current bus address.
    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_GPE,
        WIN_CPU,
        WIN_SLOT,
        WIN_EJECT
    } win_e;
endpackage

// File: rtl/hp_gpe_evtreg.sv
`timescale 1ns/1ps
// Event status / enable register pair with byte-lane access.
// Status bits are write-one-to-clear per byte; enable bytes are replaced.
// Assumes at most one bus write per cycle; same-cycle event sets win over clears.
module hp_gpe_evtreg
    import hp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           byte_sel,
    input  logic [7:0]           wdata,
    input  logic                 cpu_evt,
    input  logic                 slot_evt,
    output logic [EVT_REG_W-1:0] sts_q,
    output logic [EVT_REG_W-1:0] en_q,
    output logic [7:0]           rd_byte,
    output logic                 sci_pulse
);
    logic [EVT_REG_W-1:0] sts_n;
    logic [EVT_REG_W-1:0] en_n;
    logic [EVT_REG_W-1:0] clr_mask;

    // Next-state: byte-lane clear/replace, then event sets on top.
    always_comb begin
        clr_mask = byte_sel[0] ? {wdata, 8'h00} : {8'h00, wdata};
        sts_n    = sts_q;
        en_n     = en_q;
        if (wr_en && !byte_sel[1]) begin
            sts_n = sts_q & ~clr_mask;
        end
        if (wr_en && byte_sel[1]) begin
            if (byte_sel[0]) en_n[15:8] = wdata;
            else             en_n[7:0]  = wdata;
        end
        if (cpu_evt)  sts_n[STS_CPU_BIT]  = 1'b1;
        if (slot_evt) sts_n[STS_SLOT_BIT] = 1'b1;
    end

    // Register update and enable-gated interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q     <= '0;
            en_q      <= '0;
            sci_pulse <= 1'b0;
        end else begin
            sts_q     <= sts_n;
            en_q      <= en_n;
            sci_pulse <= (cpu_evt && en_q[STS_CPU_BIT]) ||
                         (slot_evt && en_q[STS_SLOT_BIT]);
        end
    end

    // Read byte selection.
    always_comb begin
        case (byte_sel)
            2'd0:    rd_byte = sts_q[7:0];
            2'd1:    rd_byte = sts_q[15:8];
            2'd2:    rd_byte = en_q[7:0];
            default: rd_byte = en_q[15:8];
        endcase
    end
endmodule

// File: rtl/hp_cpu_presence.sv
`timescale 1ns/1ps
// Processor presence bitmap, eight processors per byte, bus-read-only.
// Only hotplug events change it; reset marks the first INIT_CPUS present.
module hp_cpu_presence #(
    parameter int NUM_BYTES = 32,
    parameter int INIT_CPUS = 6,
    localparam int NBITS    = NUM_BYTES * 8,
    localparam int ID_W     = $clog2(NBITS),
    localparam int IDX_W    = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             evt_add,
    input  logic [ID_W-1:0]  evt_id,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    logic [NBITS-1:0] map_q;

    // Builds the reset image: one bit per initially present processor.
    function automatic logic [NBITS-1:0] reset_image();
        logic [NBITS-1:0] img;
        for (int i = 0; i < NBITS; i++) img[i] = (i < INIT_CPUS);
        return img;
    endfunction

    // Event-driven set/clear of a single presence bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         map_q <= reset_image();
        else if (evt_valid) map_q[evt_id] <= evt_add;
    end

    // Byte readout for the bus.
    assign rd_byte = map_q[{rd_idx, 3'b000} +: 8];
endmodule

// File: rtl/hp_slot_masks.sv
`timescale 1ns/1ps
// Slot arrival/departure masks plus the eject request encoder.
// A slot event wipes both masks then marks one bit; it overrides a same-cycle write.
// Eject picks the lowest set bit of a nonzero written word. Assumes NUM_SLOTS <= 32.
module hp_slot_masks #(
    parameter int NUM_SLOTS = 32,
    localparam int ID_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_up,
    input  logic                 wr_dn,
    input  logic [NUM_SLOTS-1:0] wdata,
    input  logic                 evt_valid,
    input  logic                 evt_add,
    input  logic [ID_W-1:0]      evt_id,
    input  logic                 ej_wr,
    input  logic [NUM_SLOTS-1:0] ej_data,
    output logic [NUM_SLOTS-1:0] up_q,
    output logic [NUM_SLOTS-1:0] dn_q,
    output logic                 eject_valid,
    output logic [ID_W-1:0]      eject_slot
);
    logic [ID_W-1:0] low_idx;

    // Priority encoder: index of the lowest set bit of the eject word.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (ej_data[i]) low_idx = ID_W'(i);
        end
    end

    // Mask registers: event first, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (evt_valid) begin
            up_q <= '0;
            dn_q <= '0;
            if (evt_add) up_q[evt_id] <= 1'b1;
            else         dn_q[evt_id] <= 1'b1;
        end else begin
            if (wr_up) up_q <= wdata;
            if (wr_dn) dn_q <= wdata;
        end
    end

    // One-cycle eject strobe for nonzero writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eject_valid <= 1'b0;
            eject_slot  <= '0;
        end else begin
            eject_valid <= ej_wr && (ej_data != '0);
            if (ej_wr && (ej_data != '0)) eject_slot <= low_idx;
        end
    end
endmodule

// File: rtl/hp_gpe_hotplug.sv
`timescale 1ns/1ps
// Hotplug event register block: decodes four address windows onto the
// event status/enable pair, the processor presence map, the slot masks and
// the eject register. Reads are combinational; writes take effect at the clock.
module hp_gpe_hotplug
    import hp_pkg::*;
#(
    parameter logic [15:0] GPE_BASE   = 16'h0E00,
    parameter logic [15:0] CPU_BASE   = 16'h0E20,
    parameter logic [15:0] SLOT_BASE  = 16'h0E40,
    parameter logic [15:0] EJECT_BASE = 16'h0E48,
    parameter int          CPU_BYTES  = 32,
    parameter int          INIT_CPUS  = 6,
    parameter int          NUM_SLOTS  = 32,
    localparam int         CPU_ID_W   = $clog2(CPU_BYTES * 8),
    localparam int         SLOT_ID_W  = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 cpu_evt_valid,
    input  logic                 cpu_evt_add,
    input  logic [CPU_ID_W-1:0]  cpu_evt_id,
    input  logic                 slot_evt_valid,
    input  logic                 slot_evt_add,
    input  logic [SLOT_ID_W-1:0] slot_evt_id,
    output logic                 sci_pulse,
    output logic                 eject_valid,
    output logic [SLOT_ID_W-1:0] eject_slot
);
    localparam int          CPU_IDX_W = $clog2(CPU_BYTES);
    localparam logic [15:0] CPU_LEN   = 16'(CPU_BYTES);

    logic [15:0] off_gpe, off_cpu, off_slot, off_ej;
    win_e        win;
    logic [EVT_REG_W-1:0] gpe_sts, gpe_en;
    logic [7:0]  gpe_byte, cpu_byte;
    logic [NUM_SLOTS-1:0] slot_up, slot_dn;

    // Window decode from the bus address.
    always_comb begin
        off_gpe  = bus_addr - GPE_BASE;
        off_cpu  = bus_addr - CPU_BASE;
        off_slot = bus_addr - SLOT_BASE;
        off_ej   = bus_addr - EJECT_BASE;
        if      (off_gpe  < 16'd4)   win = WIN_GPE;
        else if (off_cpu  < CPU_LEN) win = WIN_CPU;
        else if (off_slot < 16'd8)   win = WIN_SLOT;
        else if (off_ej   < 16'd4)   win = WIN_EJECT;
        else                         win = WIN_NONE;
    end

    hp_gpe_evtreg u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we && (win == WIN_GPE)),
        .byte_sel  (off_gpe[1:0]),
        .wdata     (bus_wdata[7:0]),
        .cpu_evt   (cpu_evt_valid),
        .slot_evt  (slot_evt_valid),
        .sts_q     (gpe_sts),
        .en_q      (gpe_en),
        .rd_byte   (gpe_byte),
        .sci_pulse (sci_pulse)
    );

    hp_cpu_presence #(
        .NUM_BYTES (CPU_BYTES),
        .INIT_CPUS (INIT_CPUS)
    ) u_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (cpu_evt_valid),
        .evt_add   (cpu_evt_add),
        .evt_id    (cpu_evt_id),
        .rd_idx    (off_cpu[CPU_IDX_W-1:0]),
        .rd_byte   (cpu_byte)
    );

    hp_slot_masks #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_up       (bus_we && (win == WIN_SLOT) && (off_slot == 16'd0)),
        .wr_dn       (bus_we && (win == WIN_SLOT) && (off_slot == 16'd4)),
        .wdata       (bus_wdata[NUM_SLOTS-1:0]),
        .evt_valid   (slot_evt_valid),
        .evt_add     (slot_evt_add),
        .evt_id      (slot_evt_id),
        .ej_wr       (bus_we && (win == WIN_EJECT)),
        .ej_data     (bus_wdata[NUM_SLOTS-1:0]),
        .up_q        (slot_up),
        .dn_q        (slot_dn),
        .eject_valid (eject_valid),
        .eject_slot  (eject_slot)
    );

    // Read multiplexer; eject and unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        case (win)
            WIN_GPE: bus_rdata = {24'd0, gpe_byte};
            WIN_CPU: bus_rdata = {24'd0, cpu_byte};
            WIN_SLOT: begin
                if (off_slot == 16'd0)      bus_rdata = 32'(slot_up);
                else if (off_slot == 16'd4) bus_rdata = 32'(slot_dn);
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hp_gpe_hotplug_chk.sv
`timescale 1ns/1ps
// Property checker for hp_gpe_hotplug, attached by bind below.
module hp_gpe_hotplug_chk #(
    parameter logic [15:0] EJECT_BASE = 16'h0E48,
    parameter int          NUM_SLOTS  = 32,
    localparam int         SLOT_ID_W  = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [15:0]          bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 cpu_evt_valid,
    input logic                 slot_evt_valid,
    input logic                 sci_pulse,
    input logic                 eject_valid,
    input logic [SLOT_ID_W-1:0] eject_slot,
    input logic [15:0]          gpe_sts,
    input logic [15:0]          gpe_en,
    input logic [NUM_SLOTS-1:0] slot_up,
    input logic [NUM_SLOTS-1:0] slot_dn
);
    logic ej_hit;
    assign ej_hit = (bus_addr >= EJECT_BASE) && (bus_addr <= EJECT_BASE + 16'd3);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sci_pulse && !eject_valid));

    p_cpu_sets_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_evt_valid |=> gpe_sts[2]);

    p_slot_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_evt_valid |=> gpe_sts[1]);

    p_slot_single_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_evt_valid |=> ($countones({slot_up, slot_dn}) == 1));

    p_pulse_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sci_pulse |-> $past((cpu_evt_valid && gpe_en[2]) || (slot_evt_valid && gpe_en[1])));

    p_eject_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> $past(bus_we && ej_hit && (bus_wdata != 32'd0)));

    p_eject_lowest_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eject_valid |-> ((($past(bus_wdata) >> eject_slot) & 32'd1) == 32'd1) &&
                        (($past(bus_wdata) & ((32'd1 << eject_slot) - 32'd1)) == 32'd0));

    p_eject_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ej_hit |-> (bus_rdata == 32'd0));
endmodule

bind hp_gpe_hotplug hp_gpe_hotplug_chk #(
    .EJECT_BASE (EJECT_BASE),
    .NUM_SLOTS  (NUM_SLOTS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .cpu_evt_valid  (cpu_evt_valid),
    .slot_evt_valid (slot_evt_valid),
    .sci_pulse      (sci_pulse),
    .eject_valid    (eject_valid),
    .eject_slot     (eject_slot),
    .gpe_sts        (gpe_sts),
    .gpe_en         (gpe_en),
    .slot_up        (slot_up),
    .slot_dn        (slot_dn)
);

// File: tb/hp_gpe_hotplug_tb.sv
`timescale 1ns/1ps
module hp_gpe_hotplug_tb;
    localparam logic [15:0] GB = 16'h0E00;
    localparam logic [15:0] CB = 16'h0E20;
    localparam logic [15:0] SB = 16'h0E40;
    localparam logic [15:0] EB = 16'h0E48;
    localparam int INIT = 6;
    localparam logic [15:0] IDLE = 16'hFFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = IDLE;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_evt_valid = 1'b0, cpu_evt_add = 1'b0;
    logic [7:0]  cpu_evt_id = '0;
    logic        slot_evt_valid = 1'b0, slot_evt_add = 1'b0;
    logic [4:0]  slot_evt_id = '0;
    logic        sci_pulse, eject_valid;
    logic [4:0]  eject_slot;

    int n_chk = 0, n_bad = 0;
    logic [15:0]  m_sts = '0, m_en = '0;
    logic [255:0] m_pres;
    logic [31:0]  m_up = '0, m_dn = '0;
    logic [31:0]  rd;

    always #2.5 clk = ~clk;

    hp_gpe_hotplug #(.GPE_BASE(GB), .CPU_BASE(CB), .SLOT_BASE(SB), .EJECT_BASE(EB),
                     .CPU_BYTES(32), .INIT_CPUS(INIT), .NUM_SLOTS(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_evt_valid(cpu_evt_valid), .cpu_evt_add(cpu_evt_add), .cpu_evt_id(cpu_evt_id),
        .slot_evt_valid(slot_evt_valid), .slot_evt_add(slot_evt_add), .slot_evt_id(slot_evt_id),
        .sci_pulse(sci_pulse), .eject_valid(eject_valid), .eject_slot(eject_slot));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0; bus_addr = IDLE; #1;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata; bus_addr = IDLE;
    endtask

    task automatic check_regs(input string req);
        do_rd(GB + 16'd0, rd); chk(req, rd, {24'd0, m_sts[7:0]});
        do_rd(GB + 16'd1, rd); chk(req, rd, {24'd0, m_sts[15:8]});
        do_rd(GB + 16'd2, rd); chk(req, rd, {24'd0, m_en[7:0]});
        do_rd(GB + 16'd3, rd); chk(req, rd, {24'd0, m_en[15:8]});
        do_rd(SB + 16'd0, rd); chk(req, rd, m_up);
        do_rd(SB + 16'd4, rd); chk(req, rd, m_dn);
    endtask

    task automatic check_pres(input string req);
        for (int k = 0; k < 32; k++) begin
            do_rd(CB + 16'(k), rd); chk(req, rd, {24'd0, m_pres[k*8 +: 8]});
        end
    endtask

    task automatic cpu_evt(input int id, input logic add);
        logic exp_p;
        exp_p = m_en[2];
        @(negedge clk); cpu_evt_valid = 1'b1; cpu_evt_add = add; cpu_evt_id = 8'(id);
        @(negedge clk); cpu_evt_valid = 1'b0; #1;
        chk("R7 cpu pulse", {31'd0, sci_pulse}, {31'd0, exp_p});
        m_pres[id] = add; m_sts[2] = 1'b1;
    endtask

    task automatic slot_evt(input int id, input logic add);
        logic exp_p;
        exp_p = m_en[1];
        @(negedge clk); slot_evt_valid = 1'b1; slot_evt_add = add; slot_evt_id = 5'(id);
        @(negedge clk); slot_evt_valid = 1'b0; #1;
        chk("R7 slot pulse", {31'd0, sci_pulse}, {31'd0, exp_p});
        m_up = '0; m_dn = '0;
        if (add) m_up[id] = 1'b1; else m_dn[id] = 1'b1;
        m_sts[1] = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_pres[i] = (i < INIT);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 sci_pulse", {31'd0, sci_pulse}, 32'd0);
        chk("R1 eject_valid", {31'd0, eject_valid}, 32'd0);
        check_regs("R1 regs");
        check_pres("R1 presence");

        // R3: enable byte lanes replaced independently
        do_wr(GB + 16'd2, 32'hFFFF_FF5A); m_en[7:0] = 8'h5A; check_regs("R3 enable low");
        do_wr(GB + 16'd3, 32'h0000_00C3); m_en[15:8] = 8'hC3; check_regs("R3 enable high");
        do_wr(GB + 16'd2, 32'h0000_0004); m_en[7:0] = 8'h04; check_regs("R3 enable low again");

        // R5 + R7: processor sweep, pulses while enable bit 2 set
        for (int id = 0; id < 128; id += 3) cpu_evt(id, 1'b1);
        do_wr(GB + 16'd2, 32'h0000_0002); m_en[7:0] = 8'h02;
        for (int id = 128; id < 256; id += 3) cpu_evt(id, 1'b1);
        for (int id = 0; id < 256; id += 6) cpu_evt(id, 1'b0);
        check_pres("R5 presence after sweep");
        check_regs("R5 status bit 2");

        // R4: presence writes ignored
        for (int k = 0; k < 32; k++) do_wr(CB + 16'(k), 32'h0000_00FF ^ 32'(k));
        check_pres("R4 presence unchanged");

        // R6 + R7: slot sweep with enable bit 1 set
        for (int s = 0; s < 32; s++) begin
            slot_evt(s, (s % 2) == 0);
            do_rd(SB + 16'd0, rd); chk("R6 up mask", rd, m_up);
            do_rd(SB + 16'd4, rd); chk("R6 down mask", rd, m_dn);
        end
        do_wr(GB + 16'd2, 32'h0000_0000); m_en[7:0] = 8'h00;
        slot_evt(17, 1'b1);
        cpu_evt(40, 1'b1);
        check_regs("R6 status bits");

        // R2: W1C per byte
        do_wr(GB + 16'd1, 32'h0000_00FF); check_regs("R2 high-byte clear leaves low");
        do_wr(GB + 16'd0, 32'h0000_0002); m_sts[1] = 1'b0; check_regs("R2 clear bit 1 only");
        do_wr(GB + 16'd0, 32'h0000_00FB); check_regs("R2 zero-bit keeps bit 2");
        do_wr(GB + 16'd0, 32'h0000_0004); m_sts[2] = 1'b0; check_regs("R2 clear bit 2");

        // R8: software mask writes
        do_wr(SB + 16'd0, 32'hA5A5_0F0F); m_up = 32'hA5A5_0F0F;
        do_wr(SB + 16'd4, 32'h1234_8001); m_dn = 32'h1234_8001;
        check_regs("R8 mask write");

        // R9: eject lowest set bit, zero write, reads zero
        for (int s = 0; s < 32; s++) begin
            do_wr(EB + 16'(s % 4), 32'hFFFF_FFFF << s);
            chk("R9 eject valid", {31'd0, eject_valid}, 32'd1);
            chk("R9 eject slot", {27'd0, eject_slot}, 32'(s));
            @(negedge clk); #1;
            chk("R9 eject one cycle", {31'd0, eject_valid}, 32'd0);
        end
        do_wr(EB, 32'd0);
        chk("R9 zero write no strobe", {31'd0, eject_valid}, 32'd0);
        do_rd(EB, rd); chk("R9 eject reads zero", rd, 32'd0);
        do_rd(EB + 16'd3, rd); chk("R9 eject reads zero", rd, 32'd0);

        // R10: unmapped addresses
        do_wr(GB + 16'd4, 32'hFFFF_FFFF);
        do_wr(SB + 16'd2, 32'hFFFF_FFFF);
        do_wr(EB + 16'd4, 32'hFFFF_FFFF);
        do_wr(16'h0000, 32'hFFFF_FFFF);
        chk("R10 no eject from gap", {31'd0, eject_valid}, 32'd0);
        check_regs("R10 registers untouched");
        do_rd(GB + 16'd4, rd); chk("R10 gap reads zero", rd, 32'd0);
        do_rd(EB + 16'd4, rd); chk("R10 gap reads zero", rd, 32'd0);
        do_rd(SB + 16'd2, rd); chk("R10 unaligned slot reads zero", rd, 32'd0);

        // R11: event beats same-cycle bus write
        m_sts = '0;
        do_wr(GB + 16'd0, 32'h0000_00FF);
        cpu_evt(3, 1'b1);
        @(negedge clk); slot_evt_valid = 1'b1; slot_evt_add = 1'b1; slot_evt_id = 5'd9;
        bus_addr = GB; bus_we = 1'b1; bus_wdata = 32'h0000_0006;
        @(negedge clk); slot_evt_valid = 1'b0; bus_we = 1'b0; bus_addr = IDLE; #1;
        m_sts[2] = 1'b0; m_sts[1] = 1'b1; m_up = 32'h0000_0200; m_dn = '0;
        check_regs("R11 status set beats clear");
        @(negedge clk); slot_evt_valid = 1'b1; slot_evt_add = 1'b0; slot_evt_id = 5'd4;
        bus_addr = SB; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); slot_evt_valid = 1'b0; bus_we = 1'b0; bus_addr = IDLE; #1;
        m_up = '0; m_dn = 32'h0000_0010;
        check_regs("R11 event beats mask write");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule